// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This block is the trap and return controller of a five-stage, 32-bit pipelined processor. It watches the instruction in the execute stage. When that instruction is a signed arithmetic operation whose result overflows, or when one of the auxiliary fault lines rises for it, the block raises an exception in the same cycle. In that cycle it flushes the fetch, decode and execute stages, blocks the faulting instruction from writing back, and steers the program counter to the single handler entry. On the next clock edge it records the return address, the cause and the new privilege state.

The block holds three system registers: a saved return address, a cause word and a four-bit status word. Handler software reads and writes them through a move-to/move-from port. A return-from-exception instruction in the execute stage steers the program counter to the saved address and restores the privilege and enable bits that were in force before the trap. After every redirect, one bubble is forced into the decode stage. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `trap_ctl`

## Requirements
- R1: An exception is raised only when `ex_valid` is high and either a trapping overflow occurs (`ex_trap_op` and `ex_ovf` both high) or an auxiliary source bit is high. An overflow with `ex_trap_op` low, or with `ex_valid` low, raises nothing.
- R2: On the clock edge that ends an exception cycle, the saved return address becomes `ex_pc + 4`.
- R3: An exception caused by overflow alone leaves the cause word equal to 0x00000030.
- R4: In an exception cycle, `pc_redir_valid` is high and `pc_redir_pc` is 0x80000180.
- R5: In an exception cycle, `flush_if`, `flush_id` and `flush_ex` are all high.
- R6: In an exception cycle, `wb_block` is high. It is low in every other cycle.
- R7: Status bit 0 is the exception enable and bit 1 is kernel mode. Bits 3 and 2 hold the saved kernel and enable bits. Taking an exception copies bits 1:0 into bits 3:2, sets kernel mode and clears the enable. `kernel_mode` mirrors bit 1. After reset, the status reads 0x1.
- R8: A return instruction (`ex_valid` and `ex_eret` high, with no exception in the same cycle) redirects to the saved return address and raises `flush_if` and `flush_id`, but not `flush_ex`. On the next edge it copies status bits 3:2 back into bits 1:0.
- R9: Register selectors are 12 for status, 13 for cause and 14 for the return address. Reads are combinational, and any other selector reads 0. A write lands on the next edge. An exception in the same cycle overrides a write, and a return overrides a same-cycle status write.
- R10: Auxiliary source i sets cause bit 8+i whenever it is present at an exception. Bits 6:2 hold the code of the winning source: overflow (code 12) beats every auxiliary source, and a lower auxiliary index beats a higher one. Auxiliary source i has code 13+i.
- R11: A software write to the return address is seen by a return in the next cycle. A write in the same cycle as the return is forwarded to the redirect target.
- R12: While the enable bit is clear, exception sources are ignored: there is no redirect, no flush, no writeback block, and the saved return address and cause word do not change.
- R13: In the cycle after any redirect, `flush_id` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_trap_op | input | 1 | Instruction is a signed op that traps on overflow |
| ex_ovf | input | 1 | ALU overflow flag |
| ex_aux | input | AUX_N (2) | Auxiliary exception sources |
| ex_eret | input | 1 | Instruction is a return-from-exception |
| ex_pc | input | XLEN (32) | PC of the execute-stage instruction |
| cp_we | input | 1 | System register write strobe |
| cp_wsel | input | 5 | Write selector |
| cp_wdata | input | XLEN | Write data |
| cp_rsel | input | 5 | Read selector |
| cp_rdata | output | XLEN | Read data |
| flush_if | output | 1 | Kill the fetch-stage instruction |
| flush_id | output | 1 | Kill the decode-stage instruction |
| flush_ex | output | 1 | Kill the execute-stage instruction |
| wb_block | output | 1 | Suppress register and memory writes of the faulting instruction |
| pc_redir_valid | output | 1 | Override the next PC |
| pc_redir_pc | output | XLEN | Next PC when redirecting |
| kernel_mode | output | 1 | Privileged mode flag |

## Verification
Two functions can land in the same cycle.

- A software write to the return address or cause word can coincide with an exception. The bench provokes this by raising overflow while the write strobe carries a distinct value. It then reads back the register to confirm that the hardware value, `ex_pc + 4`, won.
- A return can coincide with a write to the return address. The bench drives both at once and checks that the redirect target equals the data being written, not the stale register.

Overflow combined with auxiliary sources checks the cause priority and the pending bits.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned SEL_W   = 5;
  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  localparam int unsigned ST_W   = 4;
  localparam int unsigned ST_EN  = 0;
  localparam int unsigned ST_KM  = 1;
  localparam int unsigned ST_PEN = 2;
  localparam int unsigned ST_PKM = 3;

  localparam int unsigned CODE_W   = 5;
  localparam int unsigned CODE_LSB = 2;

  localparam logic [ST_W-1:0] ST_RESET = 4'b0001;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/trap_detect.sv
module trap_detect #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned AUX_N     = 2,
  parameter int unsigned OVF_CODE  = 12,
  parameter int unsigned AUX_CODE0 = 13,
  parameter int unsigned PEND_LSB  = 8
) (
  input  logic             ex_valid,
  input  logic             ex_trap_op,
  input  logic             ex_ovf,
  input  logic [AUX_N-1:0] ex_aux,
  input  logic             exc_en,
  output logic             take,
  output logic [XLEN-1:0]  cause_new
);
  import trap_pkg::*;

  localparam int unsigned PEND_MSB = PEND_LSB + AUX_N - 1;

  logic                  ovf_hit;
  logic [AUX_N-1:0]      aux_hit;
  logic [CODE_W-1:0]     code;

  assign ovf_hit = ex_valid & ex_trap_op & ex_ovf;
  assign aux_hit = ex_aux & {AUX_N{ex_valid}};
  assign take    = exc_en & (ovf_hit | (|aux_hit));

  // priority: overflow first, then the lowest auxiliary index
  always_comb begin
    code = CODE_W'(OVF_CODE);
    if (!ovf_hit) begin
      for (int i = AUX_N - 1; i >= 0; i--) begin
        if (aux_hit[i]) code = CODE_W'(AUX_CODE0 + i);
      end
    end
  end

  always_comb begin
    cause_new = '0;
    cause_new[CODE_LSB +: CODE_W]   = code;
    cause_new[PEND_MSB:PEND_LSB]    = aux_hit;
  end
endmodule

// File: rtl/trap_csr.sv
module trap_csr #(
  parameter int unsigned XLEN = 32
) (
  input  logic                      clk,
  input  logic                      rst_q_n,
  input  logic                      take,
  input  logic [XLEN-1:0]           cause_new,
  input  logic [XLEN-1:0]           ex_pc,
  input  logic                      eret_fire,
  input  logic                      cp_we,
  input  logic [trap_pkg::SEL_W-1:0] cp_wsel,
  input  logic [XLEN-1:0]           cp_wdata,
  input  logic [trap_pkg::SEL_W-1:0] cp_rsel,
  output logic [XLEN-1:0]           cp_rdata,
  output logic [XLEN-1:0]           eret_target,
  output logic [XLEN-1:0]           cause_q,
  output logic                      exc_en,
  output logic                      kmode
);
  import trap_pkg::*;

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] epc_q, epc_d, cause_d;
  logic [ST_W-1:0] stat_q, stat_d;
  logic            epc_en, cause_en, stat_en;
  logic            wr_epc, wr_cause, wr_stat;

  assign wr_epc   = cp_we & (cp_wsel == SEL_EPC);
  assign wr_cause = cp_we & (cp_wsel == SEL_CAUSE);
  assign wr_stat  = cp_we & (cp_wsel == SEL_STATUS);

  // next-state logic: hardware trap beats software, return beats status write
  always_comb begin
    epc_d    = epc_q;
    cause_d  = cause_q;
    stat_d   = stat_q;
    epc_en   = 1'b0;
    cause_en = 1'b0;
    stat_en  = 1'b0;
    if (take) begin
      epc_d    = ex_pc + PC_STEP;
      cause_d  = cause_new;
      stat_d   = {stat_q[ST_KM], stat_q[ST_EN], 1'b1, 1'b0};
      epc_en   = 1'b1;
      cause_en = 1'b1;
      stat_en  = 1'b1;
    end else begin
      if (wr_epc) begin
        epc_d  = cp_wdata;
        epc_en = 1'b1;
      end
      if (wr_cause) begin
        cause_d  = cp_wdata;
        cause_en = 1'b1;
      end
      if (wr_stat) begin
        stat_d  = cp_wdata[ST_W-1:0];
        stat_en = 1'b1;
      end
      if (eret_fire) begin
        stat_d  = {stat_q[ST_PKM], stat_q[ST_PEN], stat_q[ST_PKM], stat_q[ST_PEN]};
        stat_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     stat_q <= ST_RESET;
    else if (stat_en) stat_q <= stat_d;
  end

  // same-cycle write is forwarded to a return
  assign eret_target = wr_epc ? cp_wdata : epc_q;
  assign exc_en      = stat_q[ST_EN];
  assign kmode       = stat_q[ST_KM];

  always_comb begin
    case (cp_rsel)
      SEL_STATUS: cp_rdata = {{(XLEN-ST_W){1'b0}}, stat_q};
      SEL_CAUSE:  cp_rdata = cause_q;
      SEL_EPC:    cp_rdata = epc_q;
      default:    cp_rdata = '0;
    endcase
  end

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |=> (epc_q == $past(ex_pc) + PC_STEP)); // R2

  AST_KMODE_ENTRY: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |=> (kmode && !exc_en && stat_q[ST_PKM] == $past(kmode))); // R7

  AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (eret_fire && !take) |=> (kmode == $past(stat_q[ST_PKM]) && exc_en == $past(stat_q[ST_PEN]))); // R8
endmodule

// File: rtl/trap_steer.sv
module trap_steer #(
  parameter int unsigned     XLEN   = 32,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_q_n,
  input  logic            take,
  input  logic            ex_valid,
  input  logic            ex_eret,
  input  logic [XLEN-1:0] eret_target,
  output logic            eret_fire,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            wb_block
);
  logic bubble_q, bubble_d;

  assign eret_fire   = ex_valid & ex_eret & ~take;
  assign redir_valid = take | eret_fire;
  assign redir_pc    = take ? VECTOR : eret_target;

  assign flush_if = take | eret_fire;
  assign flush_id = take | eret_fire | bubble_q;
  assign flush_ex = take;
  assign wb_block = take;

  assign bubble_d = redir_valid;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) bubble_q <= 1'b0;
    else          bubble_q <= bubble_d;
  end

  AST_BUBBLE_AFTER_REDIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    redir_valid |=> flush_id); // R13

  AST_TRAP_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |-> (flush_if && flush_id && flush_ex && wb_block && redir_pc == VECTOR)); // R5
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl #(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     AUX_N     = 2,
  parameter int unsigned     OVF_CODE  = 12,
  parameter int unsigned     AUX_CODE0 = 13,
  parameter int unsigned     PEND_LSB  = 8,
  parameter logic [XLEN-1:0] VECTOR    = 32'h8000_0180
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ex_valid,
  input  logic                       ex_trap_op,
  input  logic                       ex_ovf,
  input  logic [AUX_N-1:0]           ex_aux,
  input  logic                       ex_eret,
  input  logic [XLEN-1:0]            ex_pc,
  input  logic                       cp_we,
  input  logic [trap_pkg::SEL_W-1:0] cp_wsel,
  input  logic [XLEN-1:0]            cp_wdata,
  input  logic [trap_pkg::SEL_W-1:0] cp_rsel,
  output logic [XLEN-1:0]            cp_rdata,
  output logic                       flush_if,
  output logic                       flush_id,
  output logic                       flush_ex,
  output logic                       wb_block,
  output logic                       pc_redir_valid,
  output logic [XLEN-1:0]            pc_redir_pc,
  output logic                       kernel_mode
);
  localparam logic [XLEN-1:0] OVF_ONLY_CAUSE = XLEN'(OVF_CODE) << trap_pkg::CODE_LSB;

  logic            rst_q_n;
  logic            take, exc_en, eret_fire;
  logic [XLEN-1:0] cause_new, cause_q, eret_target;

  trap_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  trap_detect #(
    .XLEN(XLEN), .AUX_N(AUX_N), .OVF_CODE(OVF_CODE),
    .AUX_CODE0(AUX_CODE0), .PEND_LSB(PEND_LSB)
  ) u_detect (
    .ex_valid   (ex_valid),
    .ex_trap_op (ex_trap_op),
    .ex_ovf     (ex_ovf),
    .ex_aux     (ex_aux),
    .exc_en     (exc_en),
    .take       (take),
    .cause_new  (cause_new)
  );

  trap_csr #(.XLEN(XLEN)) u_csr (
    .clk         (clk),
    .rst_q_n     (rst_q_n),
    .take        (take),
    .cause_new   (cause_new),
    .ex_pc       (ex_pc),
    .eret_fire   (eret_fire),
    .cp_we       (cp_we),
    .cp_wsel     (cp_wsel),
    .cp_wdata    (cp_wdata),
    .cp_rsel     (cp_rsel),
    .cp_rdata    (cp_rdata),
    .eret_target (eret_target),
    .cause_q     (cause_q),
    .exc_en      (exc_en),
    .kmode       (kernel_mode)
  );

  trap_steer #(.XLEN(XLEN), .VECTOR(VECTOR)) u_steer (
    .clk         (clk),
    .rst_q_n     (rst_q_n),
    .take        (take),
    .ex_valid    (ex_valid),
    .ex_eret     (ex_eret),
    .eret_target (eret_target),
    .eret_fire   (eret_fire),
    .redir_valid (pc_redir_valid),
    .redir_pc    (pc_redir_pc),
    .flush_if    (flush_if),
    .flush_id    (flush_id),
    .flush_ex    (flush_ex),
    .wb_block    (wb_block)
  );

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take && ex_trap_op && ex_ovf && ex_aux == '0) |=> (cause_q == OVF_ONLY_CAUSE)); // R3

  AST_IGNORED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!exc_en && !eret_fire) |-> (!pc_redir_valid && !wb_block && !flush_ex)); // R12

  AST_CAUSE_STABLE_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!exc_en && !cp_we) |=> $stable(cause_q)); // R12
endmodule

// File: tb/trap_ctl_tb.sv
module trap_ctl_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ex_valid, ex_trap_op, ex_ovf, ex_eret;
  logic [1:0]      ex_aux;
  logic [XLEN-1:0] ex_pc;
  logic            cp_we;
  logic [4:0]      cp_wsel, cp_rsel;
  logic [XLEN-1:0] cp_wdata, cp_rdata;
  logic            flush_if, flush_id, flush_ex, wb_block, pc_redir_valid, kernel_mode;
  logic [XLEN-1:0] pc_redir_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  trap_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_trap_op(ex_trap_op),
    .ex_ovf(ex_ovf), .ex_aux(ex_aux), .ex_eret(ex_eret), .ex_pc(ex_pc),
    .cp_we(cp_we), .cp_wsel(cp_wsel), .cp_wdata(cp_wdata), .cp_rsel(cp_rsel),
    .cp_rdata(cp_rdata), .flush_if(flush_if), .flush_id(flush_id),
    .flush_ex(flush_ex), .wb_block(wb_block), .pc_redir_valid(pc_redir_valid),
    .pc_redir_pc(pc_redir_pc), .kernel_mode(kernel_mode)
  );

  typedef struct packed {
    logic        vld;
    logic        top;
    logic        ovf;
    logic [1:0]  aux;
    logic        ert;
    logic [31:0] pc;
    logic        e_rd;
    logic [31:0] e_tgt;
    logic [2:0]  e_fl;   // {if,id,ex}
    logic        e_wb;
    logic        e_km;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1,1'b0,1'b0,2'b00,1'b0,32'h40,       1'b0,32'h0,        3'b000,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,2'b00,1'b0,32'h44,       1'b0,32'h0,        3'b000,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,2'b00,1'b0,32'h48,       1'b0,32'h0,        3'b000,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,2'b00,1'b0,32'h4C,       1'b1,32'h80000180, 3'b111,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,2'b00,1'b0,32'h80000180, 1'b0,32'h0,        3'b010,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,2'b00,1'b1,32'h80000184, 1'b1,32'h50,       3'b110,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,2'b00,1'b0,32'h0,        1'b0,32'h0,        3'b010,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,2'b00,1'b0,32'h60,       1'b0,32'h0,        3'b000,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ex_valid = 0; ex_trap_op = 0; ex_ovf = 0; ex_aux = 0; ex_eret = 0; ex_pc = 0;
    cp_we = 0; cp_wsel = 0; cp_wdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [4:0] sel, input logic [31:0] exp, input string tag);
    cp_rsel = sel;
    #1;
    chk(tag, cp_rdata, exp);
  endtask

  task automatic trap(input logic ovf, input logic [1:0] aux, input logic [31:0] pc, input string tag);
    ex_valid = 1; ex_trap_op = ovf; ex_ovf = ovf; ex_aux = aux; ex_pc = pc;
    #1;
    chk({tag, " redirect"}, {31'b0, pc_redir_valid}, 32'd1);
    chk({tag, " vector"}, pc_redir_pc, 32'h80000180);
    step();
  endtask

  task automatic do_eret(input logic [31:0] exp_tgt, input string tag);
    ex_valid = 1; ex_eret = 1;
    #1;
    chk({tag, " eret target"}, pc_redir_pc, exp_tgt);
    chk({tag, " eret flush"}, {29'b0, flush_if, flush_id, flush_ex}, 32'b110);
    step();
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    cp_rsel = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state R7 R9
    rd(5'd12, 32'h1, "R7 status after reset");
    rd(5'd13, 32'h0, "R9 cause after reset");
    rd(5'd14, 32'h0, "R9 epc after reset");
    rd(5'd3,  32'h0, "R9 unmapped selector");
    chk("R6 idle outputs", {28'b0, flush_if, flush_id, flush_ex, wb_block}, 32'h0);

    // vector walk R1 R4 R5 R6 R8 R12 R13
    foreach (VECS[k]) begin
      ex_valid = VECS[k].vld; ex_trap_op = VECS[k].top; ex_ovf = VECS[k].ovf;
      ex_aux = VECS[k].aux; ex_eret = VECS[k].ert; ex_pc = VECS[k].pc;
      #1;
      chk($sformatf("R1 R4 vec%0d redirect", k), {31'b0, pc_redir_valid}, {31'b0, VECS[k].e_rd});
      if (VECS[k].e_rd)
        chk($sformatf("R4 R8 vec%0d target", k), pc_redir_pc, VECS[k].e_tgt);
      chk($sformatf("R5 R13 vec%0d flush", k), {29'b0, flush_if, flush_id, flush_ex}, {29'b0, VECS[k].e_fl});
      chk($sformatf("R6 vec%0d wb_block", k), {31'b0, wb_block}, {31'b0, VECS[k].e_wb});
      chk($sformatf("R7 vec%0d kernel", k), {31'b0, kernel_mode}, {31'b0, VECS[k].e_km});
      step();
    end

    rd(5'd13, 32'h30, "R3 cause after overflow");
    rd(5'd14, 32'h50, "R2 epc is pc+4");
    rd(5'd12, 32'h5,  "R8 status restored");

    // R11 write epc then return next cycle
    cp_we = 1; cp_wsel = 5'd14; cp_wdata = 32'h4C;
    step();
    do_eret(32'h4C, "R11 sequential");
    chk("R13 bubble after eret", {31'b0, flush_id}, 32'd1);
    // R11 same-cycle forward
    cp_we = 1; cp_wsel = 5'd14; cp_wdata = 32'h60;
    do_eret(32'h60, "R11 forwarded");
    rd(5'd14, 32'h60, "R11 epc holds written value");

    // R10 multi-source
    trap(1'b1, 2'b10, 32'h100, "R10 ovf+aux1");
    rd(5'd13, 32'h230, "R10 cause ovf+aux1");
    rd(5'd14, 32'h104, "R2 epc second trap");
    rd(5'd12, 32'h6,   "R7 status in handler");
    do_eret(32'h104, "R8 return");
    trap(1'b0, 2'b01, 32'h200, "R10 aux0");
    rd(5'd13, 32'h134, "R10 cause aux0 only");
    do_eret(32'h204, "R8 return2");
    trap(1'b0, 2'b11, 32'h210, "R10 aux both");
    rd(5'd13, 32'h334, "R10 cause aux0 wins");
    do_eret(32'h214, "R8 return3");

    // R9 trap beats same-cycle software write
    cp_we = 1; cp_wsel = 5'd14; cp_wdata = 32'hDEAD0000;
    trap(1'b1, 2'b00, 32'h300, "R9 collide");
    rd(5'd14, 32'h304, "R9 trap wins over epc write");
    cp_we = 1; cp_wsel = 5'd12; cp_wdata = 32'h0;
    do_eret(32'h304, "R9 eret vs status write");
    rd(5'd12, 32'h5, "R9 eret wins over status write");

    // R9 software cause write
    cp_we = 1; cp_wsel = 5'd13; cp_wdata = 32'h0000_00A5;
    step();
    rd(5'd13, 32'hA5, "R9 cause written");

    // R12 disabled: ignored, no state change
    cp_we = 1; cp_wsel = 5'd12; cp_wdata = 32'h0;
    step();
    ex_valid = 1; ex_trap_op = 1; ex_ovf = 1; ex_aux = 2'b01; ex_pc = 32'h400;
    #1;
    chk("R12 no redirect when disabled", {31'b0, pc_redir_valid}, 32'd0);
    chk("R12 no flush when disabled", {28'b0, flush_if, flush_id, flush_ex, wb_block}, 32'h0);
    step();
    rd(5'd14, 32'h304, "R12 epc unchanged");
    rd(5'd13, 32'hA5,  "R12 cause unchanged");
    chk("R7 kernel stays clear", {31'b0, kernel_mode}, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule